// File: doc/BRIEF.md
# Tree Pseudo-LRU Replacement Unit

This block holds the replacement state for every set of an N-way set-associative cache. It is built on a binary tree per set: the cache ways are the leaves, numbered from the left, and each internal node holds one bit. Each set therefore needs N-1 bits. A node bit of 0 says the older half of the ways lies in the left subtree. A bit of 1 says it lies in the right subtree. A one-cycle access strobe, with a set index and a way, promotes that way. Every node on the way's root-to-leaf path is rewritten to point at the sibling subtree. Hits and fills use the same update path.

A separate query port returns a victim way for any set, combinationally. If the per-way valid mask shows a free way, the lowest-indexed free way is returned and the tree plays no part in that choice. Otherwise the tree is walked from the root, left on 0 and right on 1, down to a leaf. Both the walk and the update touch only log2(N) levels and are built as multiplexer trees. The way count must be a power of two from 2 to 16; any other value is rejected when the design is elaborated.

Top module: `plru_repl_unit`

## Requirements
- R1: A synchronous active-high reset clears all tree bits of every set, so afterwards every set with a full valid mask reports way 0 as victim.
- R2: With a full valid mask, the victim is the leaf reached from the root by going left on a node bit of 0 and right on 1. Nodes use heap numbering: root 0, children of node n at 2n+1 and 2n+2.
- R3: An access to way w rewrites each node on w's path to point away from the subtree holding w, and leaves every other node of that set unchanged.
- R4: In the cycle after an access to a set, a full-mask query of that set never returns the accessed way.
- R5: An access changes no tree bit of any other set.
- R6: While the access strobe is low, no tree bit changes, whatever the set and way inputs carry.
- R7: When the valid mask (bit i for way i, 1 = occupied) has any 0 bit, the victim is the lowest-indexed way whose bit is 0, whatever the tree holds.
- R8: A query in the same cycle as an access to the same set returns the victim from the state before that access.
- R9: Starting from reset, repeatedly accessing the victim of one set visits the ways in bit-reversed index order (for 8 ways: 0, 4, 2, 6, 1, 5, 3, 7), then repeats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe: promote `acc_way` in set `acc_set` at this edge |
| acc_set | input | SET_W | Set index of the access |
| acc_way | input | WAY_W | Way that hit or was filled |
| qry_set | input | SET_W | Set index for victim selection |
| qry_valid | input | WAYS | Occupancy mask of the queried set, bit i for way i |
| victim_way | output | WAY_W | Chosen victim way, combinational from the query inputs and current state |

## Verification
The hardest case to reach is a deep or lopsided tree state in one set while other sets are being accessed. Such a state exposes a node written off-path, or a walk that follows the wrong child. The stimulus drives a long run of random accesses over a few sets and a small group of favoured ways, so the trees quickly reach irregular patterns. It interleaves queries to every set against a bench model that holds all the per-set states. Directed steps add to this. They cover the bit-reversed fill order from reset, a same-cycle query and access to one set, and a run of strobe-low cycles with changing set and way inputs.

// File: rtl/plru_pkg.sv
package plru_pkg;

    localparam int MAX_WAYS  = 16;
    localparam int MAX_LV    = 4;
    localparam int MAX_NODES = MAX_WAYS - 1;

    typedef logic [MAX_NODES-1:0] node_vec_t;
    typedef logic [MAX_LV-1:0]    way_idx_t;

    typedef enum logic {
        SRC_TREE = 1'b0,
        SRC_FREE = 1'b1
    } vict_src_e;

    // Walk a tree of lv levels: 0 goes left, 1 goes right.
    function automatic way_idx_t walk_tree(input node_vec_t bits, input int lv);
        int       node;
        way_idx_t w;
        node = 0;
        w    = '0;
        for (int l = 0; l < lv; l++) begin
            w    = {w[MAX_LV-2:0], bits[node]};
            node = 2 * node + 1 + int'(bits[node]);
        end
        return w;
    endfunction

    function automatic bit ways_ok(input int ways);
        return (ways >= 2) && (ways <= MAX_WAYS) && ((ways & (ways - 1)) == 0);
    endfunction

endpackage

// File: rtl/plru_state_store.sv
module plru_state_store #(
    parameter int SETS  = 16,
    parameter int NODES = 7,
    parameter int SET_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  logic [NODES-1:0] wr_bits,
    input  logic [SET_W-1:0] rd_u_set,
    output logic [NODES-1:0] rd_u_bits,
    input  logic [SET_W-1:0] rd_q_set,
    output logic [NODES-1:0] rd_q_bits
);

    logic [SETS-1:0][NODES-1:0] mem;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem <= '0;
        end else if (wr_en) begin
            mem[wr_set] <= wr_bits;
        end
    end

    assign rd_u_bits = mem[rd_u_set];
    assign rd_q_bits = mem[rd_q_set];

    // R5 / R6: a set not written this cycle keeps its bits.
    for (genvar s = 0; s < SETS; s++) begin : g_hold
        p_set_hold_r5: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && (wr_set == SET_W'(s))) |=> $stable(mem[s]))
            else $error("set %0d changed without a write", s);
    end

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(mem))
        else $error("state changed while strobe low");

endmodule

// File: rtl/plru_path_update.sv
module plru_path_update #(
    parameter int LV    = 3,
    parameter int NODES = 7
) (
    input  logic [LV-1:0]    way,
    input  logic [NODES-1:0] old_bits,
    output logic [NODES-1:0] new_bits
);
    import plru_pkg::*;

    for (genvar l = 0; l < LV; l++) begin : g_lvl
        localparam int BASE = (1 << l) - 1;
        for (genvar k = 0; k < (1 << l); k++) begin : g_node
            logic on_path;
            assign on_path = (int'(way >> (LV - l)) == k);
            // Point at the sibling of the subtree that holds the way.
            assign new_bits[BASE + k] = on_path ? ~way[LV-1-l] : old_bits[BASE + k];
        end
    end

    // R3: after the rewrite, the tree walk must leave the way's subtree at the root.
    always_comb begin
        a_away_r3: assert (walk_tree(node_vec_t'(new_bits), LV) != way_idx_t'(way))
            else $error("updated path still leads to the accessed way");
    end

endmodule

// File: rtl/plru_victim_walk.sv
module plru_victim_walk #(
    parameter int LV    = 3,
    parameter int NODES = 7
) (
    input  logic [NODES-1:0] bits,
    output logic [LV-1:0]    way
);

    logic [LV-1:0] pref [LV+1];

    assign pref[0] = '0;

    for (genvar l = 0; l < LV; l++) begin : g_step
        localparam int BASE = (1 << l) - 1;
        logic pick;
        assign pick        = bits[BASE + int'(pref[l])];
        assign pref[l + 1] = {pref[l][LV-2 >= 0 ? LV-2 : 0:0], pick} & LV'((1 << (l + 1)) - 1);
    end

    assign way = pref[LV];

endmodule

// File: rtl/plru_free_pick.sv
module plru_free_pick #(
    parameter int WAYS = 8,
    parameter int LV   = 3
) (
    input  logic [WAYS-1:0] valid,
    output logic            any_free,
    output logic [LV-1:0]   free_way
);

    always_comb begin
        free_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!valid[i]) free_way = LV'(i);
        end
    end

    assign any_free = ~&valid;

endmodule

// File: rtl/plru_repl_unit.sv
module plru_repl_unit #(
    parameter int WAYS  = 8,
    parameter int SETS  = 16,
    parameter int WAY_W = $clog2(WAYS),
    parameter int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_valid,
    input  logic [SET_W-1:0] acc_set,
    input  logic [WAY_W-1:0] acc_way,
    input  logic [SET_W-1:0] qry_set,
    input  logic [WAYS-1:0]  qry_valid,
    output logic [WAY_W-1:0] victim_way
);
    import plru_pkg::*;

    localparam int NODES = WAYS - 1;

    if (!ways_ok(WAYS)) begin : g_bad_ways
        $error("WAYS must be a power of two between 2 and 16");
    end

    logic [NODES-1:0] upd_old;
    logic [NODES-1:0] upd_new;
    logic [NODES-1:0] qry_bits;
    logic [WAY_W-1:0] tree_way;
    logic [WAY_W-1:0] free_way;
    logic             any_free;
    vict_src_e        src;

    plru_state_store #(.SETS(SETS), .NODES(NODES), .SET_W(SET_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (acc_valid),
        .wr_set    (acc_set),
        .wr_bits   (upd_new),
        .rd_u_set  (acc_set),
        .rd_u_bits (upd_old),
        .rd_q_set  (qry_set),
        .rd_q_bits (qry_bits)
    );

    plru_path_update #(.LV(WAY_W), .NODES(NODES)) u_upd (
        .way      (acc_way),
        .old_bits (upd_old),
        .new_bits (upd_new)
    );

    plru_victim_walk #(.LV(WAY_W), .NODES(NODES)) u_walk (
        .bits (qry_bits),
        .way  (tree_way)
    );

    plru_free_pick #(.WAYS(WAYS), .LV(WAY_W)) u_free (
        .valid    (qry_valid),
        .any_free (any_free),
        .free_way (free_way)
    );

    assign src        = any_free ? SRC_FREE : SRC_TREE;
    assign victim_way = (src == SRC_FREE) ? free_way : tree_way;

    // R4: the way just promoted is never the next full-mask victim of its set.
    p_not_recent_r4: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> (!((qry_set == $past(acc_set)) && (&qry_valid))
                       || (victim_way != $past(acc_way))))
        else $error("just-accessed way chosen as victim");

    // R7: a free way wins, and no lower way is free.
    p_free_first_r7: assert property (@(posedge clk) disable iff (rst)
        !(&qry_valid) |-> (!qry_valid[victim_way]
            && (((~qry_valid) & ((WAYS'(1) << victim_way) - WAYS'(1))) == '0)))
        else $error("victim is not the lowest free way");

endmodule

// File: tb/plru_repl_unit_test.sv
module plru_repl_unit_test;

    localparam int WAYS  = 8;
    localparam int SETS  = 16;
    localparam int WAY_W = 3;
    localparam int SET_W = 4;
    localparam int NODES = WAYS - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             acc_valid = 1'b0;
    logic [SET_W-1:0] acc_set = '0;
    logic [WAY_W-1:0] acc_way = '0;
    logic [SET_W-1:0] qry_set = '0;
    logic [WAYS-1:0]  qry_valid = '1;
    logic [WAY_W-1:0] victim_way;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [NODES-1:0] mdl [SETS];

    always #4 clk = ~clk;

    plru_repl_unit #(.WAYS(WAYS), .SETS(SETS)) uut (
        .clk        (clk),
        .rst        (rst),
        .acc_valid  (acc_valid),
        .acc_set    (acc_set),
        .acc_way    (acc_way),
        .qry_set    (qry_set),
        .qry_valid  (qry_valid),
        .victim_way (victim_way)
    );

    function automatic int mdl_walk(input logic [NODES-1:0] b);
        int node = 0;
        int w = 0;
        for (int l = 0; l < WAY_W; l++) begin
            w    = w * 2 + int'(b[node]);
            node = 2 * node + 1 + int'(b[node]);
        end
        return w;
    endfunction

    function automatic logic [NODES-1:0] mdl_promote(input logic [NODES-1:0] b, input int w);
        logic [NODES-1:0] r = b;
        int node = 0;
        for (int l = 0; l < WAY_W; l++) begin
            int dir = (w >> (WAY_W - 1 - l)) & 1;
            r[node] = (dir == 0);
            node = 2 * node + 1 + dir;
        end
        return r;
    endfunction

    function automatic int expect_victim(input int s, input logic [WAYS-1:0] m);
        for (int i = 0; i < WAYS; i++) if (!m[i]) return i;
        return mdl_walk(mdl[s]);
    endfunction

    function automatic int bitrev(input int v);
        int r = 0;
        for (int i = 0; i < WAY_W; i++) r = r * 2 + ((v >> i) & 1);
        return r;
    endfunction

    task automatic check(input int got, input int exp, input string tag);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: victim=%0d expected=%0d", tag, got, exp);
        end
    endtask

    // One cycle: drive at negedge, check the query before the edge, then model the edge.
    task automatic cyc(input logic av, input int s, input int w, input int qs,
                       input logic [WAYS-1:0] m, input bit chk, input string tag);
        int exp;
        @(negedge clk);
        acc_valid = av;
        acc_set   = SET_W'(s);
        acc_way   = WAY_W'(w);
        qry_set   = SET_W'(qs);
        qry_valid = m;
        #1;
        exp = expect_victim(qs, m);
        if (chk) check(int'(victim_way), exp, tag);
        if (av) mdl[s] = mdl_promote(mdl[s], w);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: victim=%0d expected=%0d", victim_way, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int v;
        for (int s = 0; s < SETS; s++) mdl[s] = '0;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: every set reports way 0 after reset.
        for (int s = 0; s < SETS; s++) begin
            @(negedge clk);
            qry_set = SET_W'(s);
            qry_valid = '1;
            #1;
            check(int'(victim_way), 0, "R1");
        end

        // R9: fill-from-victim order is bit-reversed.
        for (int i = 0; i < 2 * WAYS; i++) begin
            @(negedge clk);
            acc_valid = 1'b0;
            qry_set = 4'd3;
            qry_valid = '1;
            #1;
            check(int'(victim_way), bitrev(i % WAYS), "R9");
            v = int'(victim_way);
            cyc(1'b1, 3, v, 3, '1, 1'b0, "R9");
        end

        // R2 / R3: directed promotions and walks in set 7.
        cyc(1'b1, 7, 5, 7, '1, 1'b1, "R2");
        cyc(1'b1, 7, 0, 7, '1, 1'b1, "R3");
        cyc(1'b0, 0, 0, 7, '1, 1'b1, "R3");
        check(int'(victim_way), 6, "R2");
        cyc(1'b1, 7, 6, 7, '1, 1'b1, "R3");
        cyc(1'b0, 0, 0, 7, '1, 1'b1, "R4");

        // R5: set 7 accesses leave set 8 at its reset victim.
        cyc(1'b0, 0, 0, 8, '1, 1'b1, "R5");
        check(int'(victim_way), 0, "R5");

        // R8: same-cycle query and access to one set sees old state.
        cyc(1'b0, 0, 0, 9, '1, 1'b1, "R8");
        cyc(1'b1, 9, 0, 9, '1, 1'b1, "R8");
        check(int'(victim_way), 0, "R8");
        cyc(1'b0, 0, 0, 9, '1, 1'b1, "R8");
        check(int'(victim_way), 4, "R8");

        // R6: strobe low with changing set and way leaves state alone.
        for (int i = 0; i < 6; i++)
            cyc(1'b0, 9, i, 9, '1, 1'b0, "R6");
        cyc(1'b0, 9, 0, 9, '1, 1'b1, "R6");
        check(int'(victim_way), 4, "R6");

        // R7: lowest free way wins over the tree.
        cyc(1'b0, 0, 0, 9, 8'b1111_0101, 1'b1, "R7");
        check(int'(victim_way), 1, "R7");
        cyc(1'b0, 0, 0, 9, 8'b0111_1111, 1'b1, "R7");
        check(int'(victim_way), 7, "R7");
        cyc(1'b0, 0, 0, 9, 8'b0000_0000, 1'b1, "R7");

        // Random mix over a few hot sets and ways (R2, R3, R5, R7).
        for (int i = 0; i < 4000; i++) begin
            logic [WAYS-1:0] m;
            int s, w, qs;
            s  = int'($urandom_range(0, 3));
            w  = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, WAYS - 1))
                                             : int'($urandom_range(0, 2)) * 3;
            qs = ($urandom_range(0, 1) == 0) ? s : int'($urandom_range(0, SETS - 1));
            m  = ($urandom_range(0, 4) == 0) ? WAYS'($urandom) : '1;
            cyc($urandom_range(0, 3) != 0, s, w % WAYS, qs, m, 1'b1,
                (&m) ? "R2" : "R7");
        end

        // R1 again: reset clears a busy state.
        @(negedge clk);
        rst = 1'b1;
        acc_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        for (int s = 0; s < SETS; s++) mdl[s] = '0;
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            qry_set = SET_W'(s);
            qry_valid = '1;
            #1;
            check(int'(victim_way), 0, "R1");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule